// File: doc/BRIEF.md
# Dual Data Pointer Unit

This block holds two 16-bit address pointers for external-data move instructions. One of them is active at any time, and the active one drives the block's address output. Software reads and writes each pointer one byte at a time through a small register port. The same port reaches a control register that chooses the active pointer and enables two automatic actions.

On each access strobe from the core, the unit can act in two ways. It can step the active pointer up or down by one, and it can swap which pointer is active. With both actions enabled, a copy loop can alternate between a source address and a destination address, and each address advances after its own use. Both actions take effect on the clock edge that samples the strobe, so they apply to the next access and not the current one.

Top module: `dual_dptr_unit`

## Requirements
- R1: After a synchronous reset, both pointers read 0x0000, the control register reads 0x00 and `dp_addr` is 0x0000.
- R2: The register addresses are 0 (pointer A low byte), 1 (pointer A high byte), 2 (pointer B low byte), 3 (pointer B high byte) and 4 (control). Each byte reads back what was written to it. Addresses 5 to 7 read 0x00.
- R3: The control register stores only bit 0 (select: 0 = pointer A, 1 = pointer B), bit 4 (step enable), bit 5 (toggle enable), bit 6 (direction of A) and bit 7 (direction of B). Bits 1 to 3 read 0.
- R4: `dp_addr` combinationally shows the pointer chosen by control bit 0.
- R5: When toggle enable is set, a strobe inverts control bit 0 at the same clock edge, so the change is visible from the next cycle.
- R6: When step enable is set, a strobe adds 1 to the active pointer if that pointer's direction bit is 0, and subtracts 1 if the bit is 1. The inactive pointer is left unchanged.
- R7: Steps wrap modulo 2^16: 0xFFFF + 1 gives 0x0000, and 0x0000 - 1 gives 0xFFFF.
- R8: When both toggle and step happen on the same strobe, the step applies to the pointer that was active during that strobe.
- R9: A byte write to a pointer in the same cycle as a strobe that would step it takes priority. The written byte is loaded, the other byte keeps its value, and no step happens.
- R10: A control write in the same cycle as a strobe loads the written value with no toggle. The pointer step for that strobe still follows the control settings from before the write.
- R11: Without a strobe, or with a strobe while step and toggle are both disabled, neither pointer nor the control register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| acc_strobe | input | 1 | One-cycle strobe per external-data access |
| dp_addr | output | 16 | Address from the active pointer |

## Verification
Register reads and `dp_addr` are combinational, so the bench samples them 1 time unit after a falling edge. A register write or a strobe is driven at a falling edge and is captured at the next rising edge, so its toggle, step or load is checked at the following falling edge, exactly one cycle later. The bench sweeps both select values, both directions, toggle on and off, and starting values at the wrap boundaries. Each expected value is computed arithmetically from the requirements.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
    localparam int DW   = 8;
    localparam int PW   = 2 * DW;
    localparam int AW   = 3;
    localparam int NPTR = 2;

    typedef logic [PW-1:0] ptr_t;

    typedef struct packed {
        logic       dir_b;
        logic       dir_a;
        logic       tog_en;
        logic       step_en;
        logic [2:0] rsvd;
        logic       sel;
    } ctrl_t;

    localparam logic [AW-1:0] ADDR_CTL = 3'd4;
    localparam logic [DW-1:0] CTL_MASK = 8'hF1;

    function automatic ptr_t step_ptr(ptr_t v, logic down);
        return down ? (v - PW'(1)) : (v + PW'(1));
    endfunction
endpackage

// File: rtl/dptr_ctrl.sv
module dptr_ctrl
    import dptr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic          strobe,
    output ctrl_t         ctl
);
    always_ff @(posedge clk) begin
        if (rst)
            ctl <= '0;
        else if (wr_en)
            ctl <= ctrl_t'(wdata & CTL_MASK);
        else if (strobe && ctl.tog_en)
            ctl.sel <= ~ctl.sel;
    end

    // R5
    toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
        strobe && ctl.tog_en && !wr_en |=> ctl.sel != $past(ctl.sel));

    // R11
    ctl_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en && !strobe |=> $stable(ctl));
endmodule

// File: rtl/dptr_reg.sv
module dptr_reg
    import dptr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [DW-1:0] wdata,
    input  logic          step,
    input  logic          down,
    output ptr_t          val
);
    always_ff @(posedge clk) begin
        if (rst)
            val <= '0;
        else if (wr_lo || wr_hi) begin
            if (wr_lo) val[DW-1:0]  <= wdata;
            if (wr_hi) val[PW-1:DW] <= wdata;
        end else if (step)
            val <= step_ptr(val, down);
    end

    // R6
    step_delta_chk: assert property (@(posedge clk) disable iff (rst)
        step && !wr_lo && !wr_hi |=>
            (val - $past(val)) == ($past(down) ? {PW{1'b1}} : PW'(1)));

    // R9
    wr_keep_other_chk: assert property (@(posedge clk) disable iff (rst)
        wr_lo && !wr_hi |=> val[PW-1:DW] == $past(val[PW-1:DW]));

    // R11
    ptr_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_lo && !wr_hi && !step |=> $stable(val));
endmodule

// File: rtl/dual_dptr_unit.sv
module dual_dptr_unit
    import dptr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          acc_strobe,
    output logic [PW-1:0] dp_addr
);
    ctrl_t            ctl;
    ptr_t             ptrs [NPTR];
    logic [NPTR-1:0]  dir_vec;

    assign dir_vec = {ctl.dir_b, ctl.dir_a};

    dptr_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (reg_wr && (reg_addr == ADDR_CTL)),
        .wdata  (reg_wdata),
        .strobe (acc_strobe),
        .ctl    (ctl)
    );

    for (genvar i = 0; i < NPTR; i++) begin : g_ptr
        localparam logic [AW-1:0] LO_ADDR = AW'(2 * i);
        localparam logic [AW-1:0] HI_ADDR = AW'(2 * i + 1);
        logic wr_lo, wr_hi, step;
        assign wr_lo = reg_wr && (reg_addr == LO_ADDR);
        assign wr_hi = reg_wr && (reg_addr == HI_ADDR);
        assign step  = acc_strobe && ctl.step_en && (ctl.sel == 1'(i));
        dptr_reg u_reg (
            .clk   (clk),
            .rst   (rst),
            .wr_lo (wr_lo),
            .wr_hi (wr_hi),
            .wdata (reg_wdata),
            .step  (step),
            .down  (dir_vec[i]),
            .val   (ptrs[i])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_CTL)
            reg_rdata = ctl;
        else if (reg_addr < AW'(2 * NPTR))
            reg_rdata = reg_addr[0] ? ptrs[reg_addr[AW-1:1]][PW-1:DW]
                                    : ptrs[reg_addr[AW-1:1]][DW-1:0];
    end

    assign dp_addr = ptrs[ctl.sel];

    // R1
    reset_addr_chk: assert property (@(posedge clk)
        rst |=> dp_addr == '0);

    // R8
    step_then_swap_chk: assert property (@(posedge clk) disable iff (rst)
        acc_strobe && ctl.step_en && ctl.tog_en && !reg_wr |=>
            dp_addr == $past(ctl.sel ? ptrs[0] : ptrs[1]));
endmodule

// File: tb/dual_dptr_unit_tb.sv
module dual_dptr_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst = 1;
    logic        reg_wr = 0;
    logic [2:0]  reg_addr = 0;
    logic [7:0]  reg_wdata = 0;
    logic [7:0]  reg_rdata;
    logic        acc_strobe = 0;
    logic [15:0] dp_addr;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_dptr_unit u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .acc_strobe(acc_strobe), .dp_addr(dp_addr)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd_ptr(input int idx, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(3'(2*idx), lo);
        rd(3'(2*idx+1), hi);
        v = {hi, lo};
    endtask

    task automatic set_ptr(input int idx, input logic [15:0] v);
        wr(3'(2*idx), v[7:0]);
        wr(3'(2*idx+1), v[15:8]);
    endtask

    task automatic pulse;
        @(negedge clk);
        acc_strobe = 1;
        @(negedge clk);
        acc_strobe = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v;
        logic [15:0] starts [5];
        starts[0] = 16'h0000; starts[1] = 16'hFFFF; starts[2] = 16'h00FF;
        starts[3] = 16'hFF00; starts[4] = 16'h1234;

        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 dp_addr", dp_addr, 16'h0000);
        rd_ptr(0, v); chk("R1 ptrA", v, 16'h0000);
        rd_ptr(1, v); chk("R1 ptrB", v, 16'h0000);
        rd(3'd4, b);  chk("R1 ctl", {8'h0, b}, 16'h0000);

        // R2 byte access and unused addresses
        set_ptr(0, 16'hA1B2); set_ptr(1, 16'hC3D4);
        rd_ptr(0, v); chk("R2 ptrA", v, 16'hA1B2);
        rd_ptr(1, v); chk("R2 ptrB", v, 16'hC3D4);
        for (int a = 5; a < 8; a++) begin
            rd(3'(a), b); chk("R2 unused", {8'h0, b}, 16'h0000);
        end

        // R3 control mask, R4 selection
        wr(3'd4, 8'hFE); rd(3'd4, b); chk("R3 ctl mask", {8'h0, b}, 16'h00F0);
        chk("R4 sel A", dp_addr, 16'hA1B2);
        wr(3'd4, 8'h01); #1; chk("R4 sel B", dp_addr, 16'hC3D4);

        // R11 strobe with no enables
        pulse; #1;
        chk("R11 dp_addr", dp_addr, 16'hC3D4);
        rd_ptr(0, v); chk("R11 ptrA", v, 16'hA1B2);
        rd(3'd4, b);  chk("R11 ctl", {8'h0, b}, 16'h0001);

        // R5 R6 R7 R8 sweep
        for (int s = 0; s < 2; s++)
        for (int d = 0; d < 2; d++)
        for (int t = 0; t < 2; t++)
        for (int k = 0; k < 5; k++) begin
            logic [15:0] pv [2];
            logic [7:0]  c;
            logic [15:0] nact;
            int          nsel;
            pv[0] = starts[k];
            pv[1] = starts[k] ^ 16'hA5C3;
            set_ptr(0, pv[0]); set_ptr(1, pv[1]);
            // bit0 sel, bit4 step, bit5 toggle, bit6 dir A, bit7 dir B
            c = 8'h10 | 8'(s) | (t ? 8'h20 : 8'h00);
            if (s == 0) c = c | (d ? 8'h40 : 8'h80);
            else        c = c | (d ? 8'h80 : 8'h40);
            wr(3'd4, c); #1;
            chk("R4 sweep pre", dp_addr, pv[s]);
            pulse; #1;
            nact = d ? (pv[s] - 16'd1) : (pv[s] + 16'd1);
            nsel = t ? 1 - s : s;
            rd_ptr(s, v);     chk("R6 R7 active", v, nact);
            rd_ptr(1 - s, v); chk("R6 inactive", v, pv[1 - s]);
            rd(3'd4, b);      chk("R5 sel", {15'h0, b[0]}, 16'(nsel));
            chk("R8 dp_addr", dp_addr, (nsel == s) ? nact : pv[1 - s]);
        end

        // R9 pointer write wins over step
        set_ptr(0, 16'h1234); wr(3'd4, 8'h10);
        @(negedge clk);
        reg_wr = 1; reg_addr = 3'd0; reg_wdata = 8'h77; acc_strobe = 1;
        @(negedge clk);
        reg_wr = 0; acc_strobe = 0;
        rd_ptr(0, v); chk("R9 write priority", v, 16'h1277);

        // R10 control write wins over toggle; step uses old settings
        wr(3'd4, 8'h30);
        @(negedge clk);
        reg_wr = 1; reg_addr = 3'd4; reg_wdata = 8'h00; acc_strobe = 1;
        @(negedge clk);
        reg_wr = 0; acc_strobe = 0;
        rd(3'd4, b);  chk("R10 ctl", {8'h0, b}, 16'h0000);
        rd_ptr(0, v); chk("R10 step", v, 16'h1278);
        chk("R10 dp_addr", dp_addr, 16'h1278);

        // R1 reset again mid-run
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0; #1;
        chk("R1 re-reset", dp_addr, 16'h0000);
        rd_ptr(1, v); chk("R1 re-reset ptrB", v, 16'h0000);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule